// File: doc/BRIEF.md
# Paged Data Memory Address Extender

This block widens the 8-bit data address of a small CPU so that it can reach an SRAM larger than 256 bytes. The SRAM is split into 256-byte pages. The CPU address selects the byte within a page, and a page number taken from one of four page registers supplies the upper physical address bits. The register that is used depends on the access class that the CPU core reports with each access.

Ordinary data accesses use the current-page register, but only when the page-mode enable input is high. When that input is low, ordinary data goes to page 0. Stack accesses always use a dedicated stack-page register. These include push, pop, call, long call, return and return from interrupt. Move-indirect reads and move-indirect writes each use their own page pointer. The page-mode enable input has no effect on stack or move-indirect accesses.

After reset every page register holds zero, so the system behaves exactly like one flat 256-byte memory. The physical address is a purely combinational function of the registered page values and the current access inputs. It therefore adds no register stage in front of the SRAM. The page registers are written through a strobe with a 2-bit register select, and they can be read back through a separate combinational read port.

Top module: `paged_addr_ext`

## Requirements
- R1: For every access class, the low 8 bits of `phys_addr` equal `cpu_addr`.
- R2: For a data access (`acc_class` = 0) with `pg_mode_en` = 1, the page field `phys_addr[PADDR_W-1:8]` equals the current-page register (register select 0).
- R3: For a data access with `pg_mode_en` = 0, the page field is 0 whatever the current-page register holds.
- R4: For a stack access (`acc_class` = 1), the page field equals the stack-page register (select 1), for either value of `pg_mode_en`.
- R5: A move-indirect read (`acc_class` = 2) takes its page from the indirect-read pointer (select 2). A move-indirect write (`acc_class` = 3) takes its page from the indirect-write pointer (select 3). Both ignore `pg_mode_en`.
- R6: After a synchronous active-low reset, all four page registers read back as 0, and every access maps to page 0.
- R7: A write with `reg_wr_en` = 1 loads `reg_wr_data` into the register chosen by `reg_wr_sel` at the next rising clock edge. An access in the same cycle as the write still uses the old value, and the other registers keep their contents.
- R8: Only the low log2(NUM_PAGES) bits of a written value are stored. Higher data bits are dropped, and they read back as 0 on `reg_rd_data`, which shows the register chosen by `reg_rd_sel`.
- R9: `phys_addr` follows changes of `cpu_addr`, `acc_class` and `pg_mode_en` within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 8 | CPU data address (byte within page) |
| acc_class | input | 2 | Access class: 0 data, 1 stack, 2 move-indirect read, 3 move-indirect write |
| pg_mode_en | input | 1 | Page mode enable (CPU flag bit) |
| reg_wr_en | input | 1 | Page register write strobe |
| reg_wr_sel | input | 2 | Register to write: 0 current, 1 stack, 2 indirect read, 3 indirect write |
| reg_wr_data | input | 8 | Value to write |
| reg_rd_sel | input | 2 | Register shown on `reg_rd_data`, same encoding |
| reg_rd_data | output | 8 | Zero-extended contents of the selected register |
| phys_addr | output | PADDR_W (10 by default) | Physical SRAM address {page, cpu_addr} |

## Verification
Access results are combinational, so they are due in the same cycle as the stimulus. The bench drives the access inputs between clock edges and samples `phys_addr` 1 ns later, with no edge in between. A register write is due one rising edge after the strobe. The bench samples the access once before that edge, where the old page must still apply, and again after the edge, where the new page must apply. Read-back values are sampled at the falling edge that follows the write edge.

// File: rtl/paged_addr_pkg.sv
// Shared types for the paged address extender.
// Assumes a fixed set of four page registers addressed by a 2-bit select.
package paged_addr_pkg;

    typedef enum logic [1:0] {
        ACC_DATA   = 2'd0,
        ACC_STACK  = 2'd1,
        ACC_MVI_RD = 2'd2,
        ACC_MVI_WR = 2'd3
    } acc_class_t;

    localparam int NUM_PAGE_REGS = 4;
    localparam int SEL_CUR = 0;
    localparam int SEL_STK = 1;
    localparam int SEL_MRD = 2;
    localparam int SEL_MWR = 3;

endpackage

// File: rtl/pax_page_reg.sv
// One page-number register.
// Stores only the PAGE_BITS low bits of a written byte and returns them
// zero-extended. Assumes PAGE_BITS >= 1 and PAGE_BITS < DATA_W.
module pax_page_reg #(
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [PAGE_BITS-1:0] page,
    output logic [DATA_W-1:0]    rd_val
);

    logic [PAGE_BITS-1:0] page_q;
    logic                 unused_hi_bits;

    // Hold the page number; load the low bits on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (wr_en)
            page_q <= wr_data[PAGE_BITS-1:0];
    end

    // Upper data bits are intentionally dropped
    assign unused_hi_bits = ^wr_data[DATA_W-1:PAGE_BITS];

    // Expose page and zero-extended read value
    always_comb begin
        page   = page_q;
        rd_val = '0;
        rd_val[PAGE_BITS-1:0] = page_q;
    end

    // R7
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> page == $past(wr_data[PAGE_BITS-1:0]));

    // R7
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(page));

    // R8
    rd_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_val == DATA_W'($past(wr_data) & DATA_W'((1 << PAGE_BITS) - 1)));

endmodule

// File: rtl/pax_page_select.sv
// Combinational page source selection and address concatenation.
// Data accesses use the current page only in page mode. Stack and
// move-indirect accesses use their own registers in every mode.
module pax_page_select
    import paged_addr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PAGE_BITS = 2,
    localparam int PADDR_W  = ADDR_W + PAGE_BITS
) (
    input  acc_class_t           acc,
    input  logic                 pg_mode_en,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [PAGE_BITS-1:0] cur_page,
    input  logic [PAGE_BITS-1:0] stk_page,
    input  logic [PAGE_BITS-1:0] mrd_page,
    input  logic [PAGE_BITS-1:0] mwr_page,
    output logic [PADDR_W-1:0]   phys_addr
);

    logic [PAGE_BITS-1:0] sel_page;

    // Choose the page source for the current access class
    always_comb begin
        unique case (acc)
            ACC_DATA:   sel_page = pg_mode_en ? cur_page : '0;
            ACC_STACK:  sel_page = stk_page;
            ACC_MVI_RD: sel_page = mrd_page;
            ACC_MVI_WR: sel_page = mwr_page;
            default:    sel_page = '0;
        endcase
    end

    // Join page and in-page offset
    assign phys_addr = {sel_page, cpu_addr};

endmodule

// File: rtl/paged_addr_ext.sv
// Paged data memory address extender (top).
// Holds the four page registers, provides the write and read-back ports,
// and drives the combinational physical address. Assumes NUM_PAGES is a
// power of two between 2 and 2**(DATA_W-1).
module paged_addr_ext
    import paged_addr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int NUM_PAGES = 4,
    localparam int PAGE_BITS = $clog2(NUM_PAGES),
    localparam int PADDR_W   = ADDR_W + PAGE_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [1:0]         acc_class,
    input  logic               pg_mode_en,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_wr_sel,
    input  logic [DATA_W-1:0]  reg_wr_data,
    input  logic [1:0]         reg_rd_sel,
    output logic [DATA_W-1:0]  reg_rd_data,
    output logic [PADDR_W-1:0] phys_addr
);

    logic [PAGE_BITS-1:0] pages   [NUM_PAGE_REGS];
    logic [DATA_W-1:0]    rd_vals [NUM_PAGE_REGS];
    acc_class_t           acc;

    assign acc = acc_class_t'(acc_class);

    // One register per page source, each with its own decoded strobe
    for (genvar gi = 0; gi < NUM_PAGE_REGS; gi++) begin : g_preg
        logic wr_hit;
        assign wr_hit = reg_wr_en && (reg_wr_sel == 2'(gi));
        pax_page_reg #(
            .DATA_W    (DATA_W),
            .PAGE_BITS (PAGE_BITS)
        ) u_preg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit),
            .wr_data (reg_wr_data),
            .page    (pages[gi]),
            .rd_val  (rd_vals[gi])
        );
    end

    // Read-back multiplexer
    assign reg_rd_data = rd_vals[reg_rd_sel];

    pax_page_select #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_sel (
        .acc        (acc),
        .pg_mode_en (pg_mode_en),
        .cpu_addr   (cpu_addr),
        .cur_page   (pages[SEL_CUR]),
        .stk_page   (pages[SEL_STK]),
        .mrd_page   (pages[SEL_MRD]),
        .mwr_page   (pages[SEL_MWR]),
        .phys_addr  (phys_addr)
    );

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[ADDR_W-1:0] == cpu_addr);

    // R2
    data_paged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_DATA && pg_mode_en) |-> phys_addr[PADDR_W-1:ADDR_W] == pages[SEL_CUR]);

    // R3
    data_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_DATA && !pg_mode_en) |-> phys_addr[PADDR_W-1:ADDR_W] == '0);

    // R4
    stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_STACK) |-> phys_addr[PADDR_W-1:ADDR_W] == pages[SEL_STK]);

    // R5
    mvi_rd_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_MVI_RD) |-> phys_addr[PADDR_W-1:ADDR_W] == pages[SEL_MRD]);

    // R5
    mvi_wr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_MVI_WR) |-> phys_addr[PADDR_W-1:ADDR_W] == pages[SEL_MWR]);

    // R7
    other_regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_sel != 2'(SEL_STK)) |=> $stable(pages[SEL_STK]));

endmodule

// File: tb/paged_addr_ext_bench.sv
// Near-exhaustive bench for the paged address extender (4 pages).
module paged_addr_ext_bench;

    localparam int NP = 4;
    localparam int PB = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [1:0]  acc_class = '0;
    logic        pg_mode_en = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = '0;
    logic [7:0]  reg_wr_data = '0;
    logic [1:0]  reg_rd_sel = '0;
    logic [7:0]  reg_rd_data;
    logic [9:0]  phys_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int mdl [4];
    bit done = 1'b0;

    always #10 clk = ~clk;

    paged_addr_ext #(.NUM_PAGES(NP)) u_paged_addr_ext (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .acc_class(acc_class),
        .pg_mode_en(pg_mode_en), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel),
        .reg_rd_data(reg_rd_data), .phys_addr(phys_addr)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int exp_page(input int cls, input bit mode);
        case (cls)
            0: return mode ? mdl[0] : 0;
            1: return mdl[1];
            2: return mdl[2];
            default: return mdl[3];
        endcase
    endfunction

    function automatic string tag_of(input int cls, input bit mode);
        case (cls)
            0: return mode ? "R2" : "R3";
            1: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Write one page register; model updates after the capturing edge
    task automatic wr_reg(input int sel, input int data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = 2'(sel); reg_wr_data = 8'(data);
        @(negedge clk);
        reg_wr_en = 1'b0;
        mdl[sel] = data % NP;
    endtask

    // Combinational access: drive, wait 1 ns, compare
    task automatic access(input int cls, input bit mode, input int addr);
        acc_class = 2'(cls); pg_mode_en = mode; cpu_addr = 8'(addr);
        #1;
        chk(tag_of(cls, mode), int'(phys_addr) >> 8, exp_page(cls, mode));
        chk("R1", int'(phys_addr) & 255, addr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mdl[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reset state of all registers and mapping
        for (int s = 0; s < 4; s++) begin
            reg_rd_sel = 2'(s); #1;
            chk("R6", reg_rd_data, 0);
        end
        for (int c = 0; c < 4; c++)
            for (int a = 0; a < 256; a += 17) begin
                acc_class = 2'(c); pg_mode_en = 1'b1; cpu_addr = 8'(a); #1;
                chk("R6", phys_addr, a);
            end

        // R8: every byte value into every register, read back truncated
        for (int s = 0; s < 4; s++)
            for (int d = 0; d < 256; d++) begin
                wr_reg(s, d);
                reg_rd_sel = 2'(s); #1;
                chk("R8", reg_rd_data, d % NP);
            end

        // R2 R3 R4 R5 R1: distinct pages per source, full address sweep
        for (int v = 0; v < 8; v++) begin
            wr_reg(0, v);
            wr_reg(1, v + 1);
            wr_reg(2, v + 2);
            wr_reg(3, v + 3);
            for (int m = 0; m < 2; m++)
                for (int c = 0; c < 4; c++)
                    for (int a = 0; a < 256; a++)
                        access(c, m[0], a);
        end

        // R7: a write is seen only after its edge, others untouched
        wr_reg(0, 1); wr_reg(1, 2); wr_reg(2, 3); wr_reg(3, 0);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = 8'h06;
        acc_class = 2'd0; pg_mode_en = 1'b1; cpu_addr = 8'h5A;
        #1;
        chk("R7", phys_addr, 1 * 256 + 'h5A);
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
        chk("R7", phys_addr, 2 * 256 + 'h5A);
        mdl[0] = 2;
        for (int c = 1; c < 4; c++) begin
            acc_class = 2'(c); #1;
            chk("R7", int'(phys_addr) >> 8, exp_page(c, 1'b1));
        end

        // R9: mid-cycle input changes reach the output without an edge
        @(negedge clk); #3;
        acc_class = 2'd1; cpu_addr = 8'hC3; #1;
        chk("R9", phys_addr, mdl[1] * 256 + 'hC3);
        acc_class = 2'd0; pg_mode_en = 1'b0; #1;
        chk("R9", phys_addr, 'hC3);
        pg_mode_en = 1'b1; #1;
        chk("R9", phys_addr, mdl[0] * 256 + 'hC3);

        // R6: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 4; i++) mdl[i] = 0;
        for (int s = 0; s < 4; s++) begin
            reg_rd_sel = 2'(s); #1;
            chk("R6", reg_rd_data, 0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule